// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an A/D converter and decides, for every finished conversion, whether the conversion-complete interrupt is raised. Each result is compared with two programmable 8-bit limits. A mode input selects whether a result inside the window or a result outside it lets the interrupt through. A result that fails the check is still a valid conversion. Only the interrupt is held back.

The converter may deliver results at 8-bit or 10-bit resolution. At 10-bit resolution only the eight most significant bits take part in the comparison. The two limit registers are loaded through a small write port and read back through a read-select input. They are locked while conversion is enabled. A write attempted during that time is dropped and sets a sticky error flag.

Top module: `adc_window_gate`

## Requirements
- R1: After reset, the upper limit reads 0xFF, the lower limit reads 0x00, and irq_o and wr_err_o are 0.
- R2: A write with wr_addr_i=0 loads the upper limit and a write with wr_addr_i=1 loads the lower limit. The new value is visible on rd_data_o (with rd_addr_i=0 for upper, 1 for lower) from the clock edge that takes the write.
- R3: A write presented while conv_en_i=1 leaves both limit registers unchanged.
- R4: A write presented while conv_en_i=1 sets wr_err_o from the next edge on. The flag stays at 1 until reset.
- R5: With range_mode_i=0, a conversion raises the interrupt when lower <= value <= upper, where both bounds are inclusive.
- R6: With range_mode_i=1, a conversion raises the interrupt when value > upper or value < lower.
- R7: With res10_i=1 the compared value is result_i[9:2]. With res10_i=0 it is result_i[7:0], and result_i[9:8] have no effect.
- R8: irq_o is a one-cycle pulse on the cycle after a conv_done_i strobe that passes the check. No pulse follows a strobe that fails the check, and no pulse appears without a strobe.
- R9: When lower > upper, both inequalities are still applied literally. In mode 0 nothing passes, and in mode 1 every value passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion-finished strobe, one cycle |
| result_i | input | 10 | Conversion result |
| res10_i | input | 1 | 1 = 10-bit result, 0 = 8-bit result |
| conv_en_i | input | 1 | Conversion enabled; locks the limits |
| range_mode_i | input | 1 | 0 = fire inside window, 1 = fire outside |
| wr_en_i | input | 1 | Limit write strobe |
| wr_addr_i | input | 1 | 0 = upper limit, 1 = lower limit |
| wr_data_i | input | 8 | Limit write data |
| rd_addr_i | input | 1 | 0 = read upper, 1 = read lower |
| rd_data_o | output | 8 | Selected limit value |
| wr_err_o | output | 1 | Sticky write-while-enabled error |
| irq_o | output | 1 | Conversion-complete interrupt pulse |

## Verification
A strobe on conv_done_i is decided at the next rising edge, so irq_o is due one cycle later and must be low again one cycle after that. A limit write and the error flag also settle at the edge that takes the strobe, while rd_data_o follows rd_addr_i without a register. The bench changes inputs on falling edges and samples results on the following falling edge. It checks the interrupt at one falling edge and its return to low at the next.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
    localparam int unsigned LIM_W_DEF = 8;
    localparam int unsigned RES_W_DEF = 10;

    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_OUTSIDE = 1'b1
    } win_mode_e;

    typedef enum logic {
        SEL_UPPER = 1'b0,
        SEL_LOWER = 1'b1
    } lim_sel_e;
endpackage

// File: rtl/adcw_limit_regs.sv
module adcw_limit_regs
    import adcw_pkg::*;
#(
    parameter int unsigned LIM_W = LIM_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             conv_en_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [LIM_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [LIM_W-1:0] hi_o,
    output logic [LIM_W-1:0] lo_o,
    output logic [LIM_W-1:0] rd_data_o,
    output logic             err_o
);
    localparam logic [LIM_W-1:0] HI_RST = {LIM_W{1'b1}};
    localparam logic [LIM_W-1:0] LO_RST = '0;

    typedef struct packed {
        logic [LIM_W-1:0] hi;
        logic [LIM_W-1:0] lo;
        logic             err;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (conv_en_i) begin
                regs_d.err = 1'b1;
            end else if (wr_sel_i == SEL_UPPER) begin
                regs_d.hi = wr_data_i;
            end else begin
                regs_d.lo = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '{hi: HI_RST, lo: LO_RST, err: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign hi_o      = regs_q.hi;
    assign lo_o      = regs_q.lo;
    assign err_o     = regs_q.err;
    assign rd_data_o = (rd_sel_i == SEL_UPPER) ? regs_q.hi : regs_q.lo;
endmodule

// File: rtl/adcw_sample_select.sv
module adcw_sample_select
    import adcw_pkg::*;
#(
    parameter int unsigned RES_W = RES_W_DEF,
    parameter int unsigned LIM_W = LIM_W_DEF
) (
    input  logic [RES_W-1:0] result_i,
    input  logic             wide_i,
    output logic [LIM_W-1:0] sample_o
);
    generate
        if (RES_W > LIM_W) begin : g_trim
            always_comb begin
                sample_o = wide_i ? result_i[RES_W-1 -: LIM_W] : result_i[LIM_W-1:0];
            end
        end else begin : g_direct
            logic unused_wide;
            assign unused_wide = wide_i;
            always_comb begin
                sample_o = result_i[LIM_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/adcw_range_eval.sv
module adcw_range_eval
    import adcw_pkg::*;
#(
    parameter int unsigned LIM_W = LIM_W_DEF
) (
    input  logic [LIM_W-1:0] sample_i,
    input  logic [LIM_W-1:0] hi_i,
    input  logic [LIM_W-1:0] lo_i,
    input  logic             mode_i,
    output logic             pass_o
);
    logic above, below;

    always_comb begin
        above = sample_i > hi_i;
        below = sample_i < lo_i;
        if (mode_i == WIN_OUTSIDE) begin
            pass_o = above | below;
        end else begin
            pass_o = ~(above | below);
        end
    end
endmodule

// File: rtl/adc_window_gate.sv
module adc_window_gate
    import adcw_pkg::*;
#(
    parameter int unsigned RES_W = RES_W_DEF,
    parameter int unsigned LIM_W = LIM_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             res10_i,
    input  logic             conv_en_i,
    input  logic             range_mode_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [LIM_W-1:0] wr_data_i,
    input  logic             rd_addr_i,
    output logic [LIM_W-1:0] rd_data_o,
    output logic             wr_err_o,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } gate_t;

    gate_t            gate_d, gate_q;
    logic [LIM_W-1:0] lim_hi, lim_lo, sample;
    logic             pass;

    adcw_limit_regs #(.LIM_W(LIM_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .conv_en_i (conv_en_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_addr_i),
        .hi_o      (lim_hi),
        .lo_o      (lim_lo),
        .rd_data_o (rd_data_o),
        .err_o     (wr_err_o)
    );

    adcw_sample_select #(.RES_W(RES_W), .LIM_W(LIM_W)) u_sel (
        .result_i (result_i),
        .wide_i   (res10_i),
        .sample_o (sample)
    );

    adcw_range_eval #(.LIM_W(LIM_W)) u_eval (
        .sample_i (sample),
        .hi_i     (lim_hi),
        .lo_i     (lim_lo),
        .mode_i   (range_mode_i),
        .pass_o   (pass)
    );

    always_comb begin
        gate_d     = gate_q;
        gate_d.irq = conv_done_i & pass;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign irq_o = gate_q.irq;
endmodule

// File: rtl/adcw_checker.sv
module adcw_checker #(
    parameter int unsigned LIM_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             conv_done_i,
    input logic             conv_en_i,
    input logic             range_mode_i,
    input logic             wr_en_i,
    input logic             wr_err_o,
    input logic             irq_o,
    input logic [LIM_W-1:0] hi,
    input logic [LIM_W-1:0] lo,
    input logic [LIM_W-1:0] sample
);
    p_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_en_i |=> ($stable(hi) && $stable(lo)));

    p_err_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && conv_en_i) |=> wr_err_o);

    p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_err_o |=> wr_err_o);

    p_inside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && !range_mode_i) |=> (irq_o == $past(sample >= lo && sample <= hi)));

    p_outside_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && range_mode_i) |=> (irq_o == $past(sample > hi || sample < lo)));

    p_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !conv_done_i |=> !irq_o);
endmodule

bind adc_window_gate adcw_checker #(.LIM_W(LIM_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .conv_done_i  (conv_done_i),
    .conv_en_i    (conv_en_i),
    .range_mode_i (range_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_err_o     (wr_err_o),
    .irq_o        (irq_o),
    .hi           (lim_hi),
    .lo           (lim_lo),
    .sample       (sample)
);

// File: tb/tb_adc_window_gate.sv
`timescale 1ns/1ps
module tb_adc_window_gate;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       conv_done_i = 1'b0;
    logic [9:0] result_i = '0;
    logic       res10_i = 1'b0;
    logic       conv_en_i = 1'b0;
    logic       range_mode_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_addr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       wr_err_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk_i = ~clk_i;

    adc_window_gate dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_lim(input logic sel, input logic [7:0] val);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = sel; wr_data_i = val;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic read_lim(input string req, input logic sel, input logic [7:0] exp);
        rd_addr_i = sel;
        #1;
        check(req, rd_data_o, exp);
    endtask

    task automatic conv(input string req, input logic [9:0] res, input logic wide,
                        input logic mode, input logic exp);
        @(negedge clk_i);
        conv_done_i = 1'b1; result_i = res; res10_i = wide; range_mode_i = mode;
        @(negedge clk_i);
        conv_done_i = 1'b0;
        check(req, irq_o, exp);
        @(negedge clk_i);
        check({req, " R8 pulse end"}, irq_o, 0);
    endtask

    task automatic t_reset();
        check("R1 irq", irq_o, 0);
        check("R1 err", wr_err_o, 0);
        read_lim("R1 upper", 1'b0, 8'hFF);
        read_lim("R1 lower", 1'b1, 8'h00);
    endtask

    task automatic t_write();
        write_lim(1'b0, 8'hC0);
        write_lim(1'b1, 8'h40);
        read_lim("R2 upper", 1'b0, 8'hC0);
        read_lim("R2 lower", 1'b1, 8'h40);
    endtask

    task automatic t_inside();
        conv("R5 lo edge", 10'h040, 1'b0, 1'b0, 1'b1);
        conv("R5 hi edge", 10'h0C0, 1'b0, 1'b0, 1'b1);
        conv("R5 mid", 10'h080, 1'b0, 1'b0, 1'b1);
        conv("R5 below", 10'h03F, 1'b0, 1'b0, 1'b0);
        conv("R5 above", 10'h0C1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_resolution();
        conv("R7 8b top bits ignored", 10'h380, 1'b0, 1'b0, 1'b1);
        conv("R7 8b top bits ignored fail", 10'h33F, 1'b0, 1'b0, 1'b0);
        conv("R7 10b mid", 10'h203, 1'b1, 1'b0, 1'b1);
        conv("R7 10b low", 10'h0FF, 1'b1, 1'b0, 1'b0);
        conv("R7 10b hi edge", 10'h303, 1'b1, 1'b0, 1'b1);
        conv("R7 10b above", 10'h304, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_outside();
        conv("R6 below", 10'h03F, 1'b0, 1'b1, 1'b1);
        conv("R6 above", 10'h0C1, 1'b0, 1'b1, 1'b1);
        conv("R6 mid", 10'h080, 1'b0, 1'b1, 1'b0);
        conv("R6 lo edge", 10'h040, 1'b0, 1'b1, 1'b0);
        conv("R6 hi edge", 10'h0C0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_no_strobe();
        @(negedge clk_i);
        result_i = 10'h080; res10_i = 1'b0; range_mode_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_i);
            check("R8 no strobe", irq_o, 0);
        end
    endtask

    task automatic t_lock();
        @(negedge clk_i);
        conv_en_i = 1'b1;
        write_lim(1'b0, 8'h11);
        write_lim(1'b1, 8'h22);
        read_lim("R3 upper locked", 1'b0, 8'hC0);
        read_lim("R3 lower locked", 1'b1, 8'h40);
        check("R4 err set", wr_err_o, 1);
        @(negedge clk_i);
        conv_en_i = 1'b0;
        @(negedge clk_i);
        check("R4 err sticky", wr_err_o, 1);
        write_lim(1'b0, 8'h30);
        read_lim("R2 write after unlock", 1'b0, 8'h30);
        check("R4 err still set", wr_err_o, 1);
    endtask

    task automatic t_inverted();
        write_lim(1'b1, 8'h50);
        conv("R9 mode0 between", 10'h040, 1'b0, 1'b0, 1'b0);
        conv("R9 mode0 at upper", 10'h030, 1'b0, 1'b0, 1'b0);
        conv("R9 mode0 at lower", 10'h050, 1'b0, 1'b0, 1'b0);
        conv("R9 mode1 between", 10'h040, 1'b0, 1'b1, 1'b1);
        conv("R9 mode1 at lower", 10'h050, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_rereset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        check("R4 err cleared by reset", wr_err_o, 0);
        read_lim("R1 upper again", 1'b0, 8'hFF);
        read_lim("R1 lower again", 1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_write();
        t_inside();
        t_resolution();
        t_outside();
        t_no_strobe();
        t_lock();
        t_inverted();
        t_rereset();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule